// File: doc/BRIEF.md
# Algebraic Word Right-Shift Unit

This unit executes the 32-bit arithmetic right-shift-word instruction of a 64-bit processor in one registered step. Each cycle it can accept one 32-bit instruction word together with two 64-bit register operands and the current summary-overflow bit. The first operand is the value to shift. The second operand supplies the shift count. The unit confirms that the word has the expected register-register encoding. It then shifts the low word of the value with sign fill, sign-extends the result to 64 bits and produces the carry flag. When the record bit is set, it also produces a 4-bit condition field.

The results appear one cycle after the input strobe, together with the destination register index and separate write enables for the register, the carry flag and the condition field. A word that fails the opcode check produces an idle output cycle in which no write enable is asserted. Instruction bits are numbered MSB-first: bit 0 is the most significant bit of the word.

Top module: `sraw_unit`

## Requirements
- R1: An instruction is legal only when bits 0–5 equal 31 and bits 10 bits 21–30 equal 792 (base word 0x7C000630). A strobed illegal word leaves `out_valid`, `gpr_we`, `carry_we` and `cond_we` at 0 in the following cycle.
- R2: `dest_idx` equals instruction bits 11–15, which are `instr[20:16]`.
- R3: Only the low 6 bits of `cnt_val` form the shift count. Bits 63:6 of `cnt_val` have no effect on any output.
- R4: A count of 0 passes `src_val[31:0]` through unchanged, sign-extended to 64 bits, and gives a carry of 0.
- R5: A count from 1 to 31 gives `src_val[31:0]` shifted right with sign fill. Carry is 1 only when `src_val[31]` is 1 and at least one 1-bit left the low end.
- R6: A count from 32 to 63 saturates the result. When `src_val[31]` is 1, the result is all ones and carry is 1. Otherwise the result is zero and carry is 0.
- R7: Bits 63:32 of `result` always copy `result[31]`. Bits 63:32 of `src_val` have no effect on any output.
- R8: Every legal instruction asserts `gpr_we` and `carry_we`, whatever the record bit holds.
- R9: When the record bit `instr[0]` is 1, `cond_we` is 1 and `cond` = {LT, GT, EQ, SO}, with LT in bit 3. LT, GT and EQ come from a signed comparison of the result with zero, and exactly one of them is 1. SO copies `so_in`. When the record bit is 0, `cond_we` is 0.
- R10: Outputs are registered with one cycle of latency after `in_valid`. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Operand holding the value to shift |
| cnt_val | input | 64 | Operand holding the shift count |
| so_in | input | 1 | Incoming summary-overflow bit |
| out_valid | output | 1 | Registered legal-instruction result is present |
| gpr_we | output | 1 | Destination register write enable |
| dest_idx | output | 5 | Destination register index |
| result | output | 64 | Sign-extended shift result |
| carry_we | output | 1 | Carry flag write enable |
| carry | output | 1 | Carry flag value |
| cond_we | output | 1 | Condition field write enable |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Random operands cover four groups of counts:
- counts of 0, 1–31 and 32–63, with arbitrary bits above the low six
- positive and negative source words
- garbage in the upper source half
- record bits of both values

Directed cases separate the carry rule from the sign rule:
- negative words that lose only zeros
- negative words that lose a single low one
- a count of exactly 32
- a count of 31 against 32
- a count operand whose upper bits are all set

Corrupted primary and extended opcode fields show that rejected words raise no write enable. A mid-stream reset and an idle cycle after a valid one show the latency and the clearing behaviour.

// File: rtl/sraw_pkg.sv
package sraw_pkg;

    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;

    localparam logic [5:0] PRIMARY_OP  = 6'd31;
    localparam logic [9:0] EXTENDED_OP = 10'd792;

    // MSB-first positions of the fields in the instruction word
    localparam int POS_PRIMARY  = 0;
    localparam int POS_DEST     = 11;
    localparam int POS_EXTENDED = 21;
    localparam int POS_RECORD   = 31;

    typedef struct packed {
        logic                 legal;
        logic                 rec;
        logic [REG_IDX_W-1:0] dst;
    } insn_fields_t;

    typedef enum logic [1:0] {
        CMP_LESS    = 2'd0,
        CMP_GREATER = 2'd1,
        CMP_EQUAL   = 2'd2
    } cmp_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    // Convert an MSB-first bit number into a conventional index
    function automatic int msb0(input int pos);
        return INSN_W - 1 - pos;
    endfunction

endpackage

// File: rtl/sraw_decode.sv
module sraw_decode
    import sraw_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      fields
);

    logic [5:0] primary;
    logic [9:0] extended;

    always_comb begin
        primary    = insn[msb0(POS_PRIMARY) -: 6];
        extended   = insn[msb0(POS_RECORD - 1) + 9 -: 10];
        fields.dst = insn[msb0(POS_DEST) -: REG_IDX_W];
        fields.rec = insn[msb0(POS_RECORD)];
        fields.legal = (primary == PRIMARY_OP) && (extended == EXTENDED_OP);
    end

    // Source and count register selectors are resolved by the register file
    logic unused_selectors;
    assign unused_selectors = ^insn[25:11];

endmodule

// File: rtl/sraw_shift_core.sv
module sraw_shift_core #(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int CNT_W = $clog2(WLEN) + 1
) (
    input  logic [WLEN-1:0]  word_in,
    input  logic [CNT_W-1:0] amount,
    output logic [XLEN-1:0]  value,
    output logic             ca
);

    localparam int STAGES = $clog2(WLEN);
    localparam int EXT_W  = XLEN - WLEN;

    logic            sgn;
    logic [WLEN-1:0] stage_w [0:STAGES];
    logic [STAGES:0] lost;
    logic            oversize;
    logic [WLEN-1:0] word_out;

    assign sgn        = word_in[WLEN-1];
    assign stage_w[0] = word_in;
    assign lost[0]    = 1'b0;

    // Logarithmic shifter; each stage also records whether a one fell off
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage_w[k+1] = amount[k] ? {{D{sgn}}, stage_w[k][WLEN-1:D]}
                                        : stage_w[k];
        assign lost[k+1]    = lost[k] | (amount[k] & (|stage_w[k][D-1:0]));
    end

    assign oversize = amount[CNT_W-1];

    always_comb begin
        if (oversize) begin
            word_out = {WLEN{sgn}};
            ca       = sgn;
        end else begin
            word_out = stage_w[STAGES];
            ca       = sgn & lost[STAGES];
        end
        value = {{EXT_W{word_out[WLEN-1]}}, word_out};
    end

endmodule

// File: rtl/sraw_cond.sv
module sraw_cond
    import sraw_pkg::*;
#(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] word,
    input  logic            so_in,
    output cond_t           cf
);

    cmp_e rel;

    always_comb begin
        if (word[WLEN-1])
            rel = CMP_LESS;
        else if (word == '0)
            rel = CMP_EQUAL;
        else
            rel = CMP_GREATER;

        cf.lt = (rel == CMP_LESS);
        cf.gt = (rel == CMP_GREATER);
        cf.eq = (rel == CMP_EQUAL);
        cf.so = so_in;
    end

endmodule

// File: rtl/sraw_unit.sv
module sraw_unit
    import sraw_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    instr,
    input  logic [XLEN-1:0]      src_val,
    input  logic [XLEN-1:0]      cnt_val,
    input  logic                 so_in,
    output logic                 out_valid,
    output logic                 gpr_we,
    output logic [REG_IDX_W-1:0] dest_idx,
    output logic [XLEN-1:0]      result,
    output logic                 carry_we,
    output logic                 carry,
    output logic                 cond_we,
    output logic [3:0]           cond
);

    localparam int CNT_W = $clog2(WLEN) + 1;

    insn_fields_t    dec;
    logic [XLEN-1:0] sh_value;
    logic            sh_ca;
    cond_t           cf;
    logic            fire;

    sraw_decode i_decode (
        .insn   (instr),
        .fields (dec)
    );

    sraw_shift_core #(
        .XLEN  (XLEN),
        .WLEN  (WLEN),
        .CNT_W (CNT_W)
    ) i_core (
        .word_in (src_val[WLEN-1:0]),
        .amount  (cnt_val[CNT_W-1:0]),
        .value   (sh_value),
        .ca      (sh_ca)
    );

    sraw_cond #(
        .WLEN (WLEN)
    ) i_cond (
        .word  (sh_value[WLEN-1:0]),
        .so_in (so_in),
        .cf    (cf)
    );

    assign fire = in_valid & dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            gpr_we    <= 1'b0;
            carry_we  <= 1'b0;
            cond_we   <= 1'b0;
            dest_idx  <= '0;
            result    <= '0;
            carry     <= 1'b0;
            cond      <= '0;
        end else begin
            out_valid <= fire;
            gpr_we    <= fire;
            carry_we  <= fire;
            cond_we   <= fire & dec.rec;
            if (fire) begin
                dest_idx <= dec.dst;
                result   <= sh_value;
                carry    <= sh_ca;
                cond     <= cf;
            end
        end
    end

    // Upper operand bits never reach the datapath
    logic unused_upper;
    assign unused_upper = ^{src_val[XLEN-1:WLEN], cnt_val[XLEN-1:CNT_W]};

    // R1
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (instr[31:26] != 6'd31 || instr[10:1] != 10'd792))
        |=> (!out_valid && !gpr_we && !carry_we && !cond_we));

    // R4
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && cnt_val[CNT_W-1:0] == '0)
        |=> (!carry && result[WLEN-1:0] == $past(src_val[WLEN-1:0])));

    // R5
    carry_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && carry) |-> result[WLEN-1]);

    // R6
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && cnt_val[CNT_W-1])
        |=> (result == {XLEN{$past(src_val[WLEN-1])}}
             && carry == $past(src_val[WLEN-1])));

    // R7
    sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}}));

    // R8
    carry_always_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (carry_we && gpr_we));

    // R9
    cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> ($countones(cond[3:1]) == 1));

endmodule

// File: tb/test_sraw_unit.sv
module test_sraw_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic [63:0] cnt_val = '0;
    logic        so_in = 1'b0;
    logic        out_valid, gpr_we, carry_we, carry, cond_we;
    logic [4:0]  dest_idx;
    logic [63:0] result;
    logic [3:0]  cond;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    sraw_unit i_sraw_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .cnt_val(cnt_val), .so_in(so_in),
        .out_valid(out_valid), .gpr_we(gpr_we), .dest_idx(dest_idx),
        .result(result), .carry_we(carry_we), .carry(carry),
        .cond_we(cond_we), .cond(cond)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: one-bit-at-a-time arithmetic shift
    task automatic ref_model(input logic [63:0] s, input logic [63:0] a,
                             output logic [63:0] r, output logic ca);
        logic [31:0] w;
        logic        gone;
        int          n;
        w    = s[31:0];
        gone = 1'b0;
        n    = int'(a[5:0]);
        for (int i = 0; i < n; i++) begin
            gone = gone | w[0];
            w    = {w[31], w[31:1]};
        end
        r  = {{32{w[31]}}, w};
        ca = s[31] & gone;
    endtask

    function automatic logic [31:0] mk_insn(input logic [4:0] rs, input logic [4:0] ra,
                                            input logic [4:0] rb, input logic rc);
        return {6'd31, rs, ra, rb, 10'd792, rc};
    endfunction

    task automatic run(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] a,
                       input logic so, input string tag);
        logic [63:0] er;
        logic        eca;
        logic        legal;
        string       rq;
        logic [3:0]  ec;
        @(negedge clk);
        in_valid = 1'b1; instr = ins; src_val = s; cnt_val = a; so_in = so;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        legal = (ins[31:26] == 6'd31) && (ins[10:1] == 10'd792);
        if (!legal) begin
            chk("R1 valid", {63'd0, out_valid}, 64'd0);
            chk("R1 enables", {60'd0, gpr_we, carry_we, cond_we, 1'b0}, 64'd0);
        end else begin
            ref_model(s, a, er, eca);
            if (tag != "")        rq = tag;
            else if (a[5:0] == 0) rq = "R4";
            else if (a[5])        rq = "R6";
            else                  rq = "R5";
            chk({rq, " result"}, result, er);
            chk({rq, " carry"}, {63'd0, carry}, {63'd0, eca});
            chk("R7 upper", {32'd0, result[63:32]}, {32'd0, {32{result[31]}}});
            chk("R2 dest", {59'd0, dest_idx}, {59'd0, ins[20:16]});
            chk("R8 enables", {61'd0, out_valid, gpr_we, carry_we}, 64'd7);
            chk("R9 cond_we", {63'd0, cond_we}, {63'd0, ins[0]});
            if (ins[0]) begin
                ec = {er[31], !er[31] && er[31:0] != 0, er[31:0] == 0, so};
                chk("R9 cond", {60'd0, cond}, {60'd0, ec});
            end
        end
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [31:0] ins;
        logic [63:0] s, a;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {60'd0, out_valid, gpr_we, carry_we, cond_we}, 64'd0);
        chk("R10 reset data", result | {59'd0, dest_idx} | {63'd0, carry} | {60'd0, cond}, 64'd0);
        rst = 1'b0;

        // Directed corner cases
        run(mk_insn(5'd3, 5'd7, 5'd9, 1'b1), 64'h0000_0000_8000_0001, 64'd0, 1'b0, "R4");
        run(mk_insn(5'd1, 5'd2, 5'd3, 1'b1), 64'hFFFF_FFFF_FFFF_FF00, 64'd8, 1'b1, "R5");
        run(mk_insn(5'd1, 5'd2, 5'd3, 1'b0), 64'h0000_0000_FFFF_FF01, 64'd1, 1'b0, "R5");
        run(mk_insn(5'd1, 5'd2, 5'd3, 1'b1), 64'h0000_0000_8000_0000, 64'd31, 1'b0, "R5");
        run(mk_insn(5'd1, 5'd2, 5'd3, 1'b1), 64'h0000_0000_8000_0000, 64'd32, 1'b0, "R6");
        run(mk_insn(5'd1, 5'd31, 5'd3, 1'b1), 64'hFFFF_FFFF_7FFF_FFFF, 64'd63, 1'b1, "R6");
        run(mk_insn(5'd1, 5'd4, 5'd3, 1'b1), 64'h1234_5678_0000_0001, 64'd1, 1'b0, "R5");
        run(mk_insn(5'd1, 5'd4, 5'd3, 1'b1), 64'h0000_0000_C000_0003, 64'hFFFF_FFFF_FFFF_FFC2, 1'b0, "R3");
        run(mk_insn(5'd1, 5'd4, 5'd3, 1'b1), 64'h0000_0000_C000_0003, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, "R3");
        run(mk_insn(5'd1, 5'd4, 5'd3, 1'b1) ^ 32'h0400_0000, 64'h8000_0001, 64'd1, 1'b0, "R1");
        run(mk_insn(5'd1, 5'd4, 5'd3, 1'b1) ^ 32'h0000_0002, 64'h8000_0001, 64'd1, 1'b0, "R1");

        // R10: one-cycle latency, output idles after the strobe
        @(negedge clk);
        chk("R10 idle", {63'd0, out_valid}, 64'd0);

        // R10: mid-stream reset clears outputs
        run(mk_insn(5'd1, 5'd9, 5'd3, 1'b1), 64'hFFFF_FFFF, 64'd4, 1'b1, "");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 mid reset", {58'd0, out_valid, gpr_we, carry_we, cond_we, carry, |result},
            64'd0);
        chk("R10 mid reset dest", {59'd0, dest_idx}, 64'd0);
        in_valid = 1'b0; rst = 1'b0;

        // Constrained random
        for (int i = 0; i < 1500; i++) begin
            ins = mk_insn(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
            if (($urandom % 8) == 0) ins = ins ^ (32'h1 << ($urandom % 31 + 1));
            s = {$urandom, $urandom};
            case ($urandom % 4)
                0: s[31:0] = $urandom % 16;
                1: s[31]   = 1'b1;
                default: ;
            endcase
            a = {$urandom, $urandom};
            case ($urandom % 4)
                0: a[5:0] = 6'd0;
                1: a[5]   = 1'b1;
                default: a[5] = 1'b0;
            endcase
            run(ins, s, a, 1'($urandom), "");
        end

        done = 1;
        report();
    end

endmodule